// File: doc/BRIEF.md
# SPI Command Slave with Text Buffer and Busy Handshake

This block is the host-facing serial front end of a text processing engine. A host acting as SPI master frames each transaction with an active-low slave select. The block samples the serial lines into the system clock domain and assembles bytes from them. It treats the first two bytes of every transaction as a 16-bit command word and reports it on a one-cycle strobe. Every byte after the command word is a payload byte. Each payload byte is strobed out for downstream logic and also written into an on-chip byte buffer, which the consumer drains through a simple read port.

The host must not overrun the buffer, so a ready line gives it flow control. The line drops once the buffer has filled to its full size less a configurable margin. That margin leaves room for bytes that are already in flight. The line rises again as soon as the consumer has drained the buffer below that level. While a transaction runs, the block returns a response byte on MISO, MSB first. The response byte is taken from an input port at the start of the transaction and again at each byte boundary.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, `ready` is 1, `miso_oe` is 0, `cmd_valid`, `wr_valid` and `rd_valid` are 0, and the buffer is empty.
- R2: A transfer is accepted only while both `cs_n` and `ss_n` are low. SCLK activity while `cs_n` is high produces no command strobe and no payload strobe.
- R3: MOSI is sampled on rising SCLK edges, MSB first. The first byte of a transaction becomes bits 15:8 of `cmd_word` and the second byte becomes bits 7:0. `cmd_valid` pulses for exactly one clock when the 16th bit arrives.
- R4: Every byte after the command word is reported on `wr_valid`/`wr_data` in arrival order and is pushed into the buffer.
- R5: If slave select rises before 16 command bits have arrived, the partial command is discarded with no strobe, and the next transaction starts again at bit 15 of a new command word.
- R6: The response byte on `rsp_byte` is captured when the transaction starts and again after each completed byte. It is shifted out on `miso` MSB first, with each bit valid while SCLK is high.
- R7: `miso_oe` is 1 during a selected transaction and returns to 0 within 4 clocks after slave select rises.
- R8: `ready` is 0 while the buffer holds at least DEPTH-MARGIN bytes (240 with the defaults DEPTH=256, MARGIN=16) and 1 while it holds fewer.
- R9: The buffer holds DEPTH (256) bytes. A payload byte that arrives while the buffer is full is still strobed on `wr_valid` but is dropped from the buffer, and the occupancy never exceeds DEPTH.
- R10: A read request on a non-empty buffer returns the oldest byte on `rd_data` with `rd_valid` high one clock later. A read request on an empty buffer raises no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCLK rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock from the host |
| ss_n | input | 1 | Active-low slave select; frames a transaction |
| cs_n | input | 1 | Active-low chip enable |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial response data to the host |
| miso_oe | output | 1 | Drive enable for MISO; low means tri-state |
| rsp_byte | input | 8 | Response byte to shift out |
| cmd_valid | output | 1 | One-cycle strobe for a complete command word |
| cmd_word | output | 16 | Received command word |
| wr_valid | output | 1 | One-cycle strobe for a payload byte |
| wr_data | output | 8 | Payload byte |
| rd_en | input | 1 | Read request to the buffer |
| rd_data | output | 8 | Byte read from the buffer |
| rd_valid | output | 1 | `rd_data` holds a byte |
| ready | output | 1 | High when the host may send more data |

## Verification
The embedded assertions check several properties on every cycle. They confirm that a command strobe lasts one cycle and that no strobe follows a deselected cycle. They confirm that occupancy never passes DEPTH and that a full buffer ignores further pushes. They also check that `ready` moves only in the direction of the occupancy change, and that an empty read yields nothing. Other behaviour can only be shown by the bench's scenarios: bit ordering into `cmd_word`, response bytes seen on MISO, payload order through the buffer, discarding of partial commands, and the exact 240-byte threshold on the way up and on the way down.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    PH_CMD_HI = 2'd0,
    PH_CMD_LO = 2'd1,
    PH_DATA   = 2'd2
  } frame_phase_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] rsp_byte,
  output logic              miso,
  output logic              miso_oe,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int BW = $clog2(BYTE_W);

  logic              sclk_q, sel_q;
  logic [BW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, cmd_hi;
  frame_phase_e      phase;

  logic              rise, fall, start, last_bit;
  logic [BYTE_W-1:0] byte_in;

  assign rise     = sel & sclk_s & ~sclk_q;
  assign fall     = sel & ~sclk_s & sclk_q;
  assign start    = sel & ~sel_q;
  assign last_bit = (bit_cnt == BW'(BYTE_W - 1));
  assign byte_in  = {rx_sh[BYTE_W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      sel_q     <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      cmd_hi    <= '0;
      cmd_word  <= '0;
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
      phase     <= PH_CMD_HI;
    end else begin
      sclk_q    <= sclk_s;
      sel_q     <= sel;
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
        phase   <= PH_CMD_HI;
      end else if (rise) begin
        rx_sh   <= byte_in;
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        if (last_bit) begin
          case (phase)
            PH_CMD_HI: begin
              cmd_hi <= byte_in;
              phase  <= PH_CMD_LO;
            end
            PH_CMD_LO: begin
              cmd_word  <= {cmd_hi, byte_in};
              cmd_valid <= 1'b1;
              phase     <= PH_DATA;
            end
            default: begin
              wr_data  <= byte_in;
              wr_valid <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  // Response shifter: load at frame start and at each byte boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh   <= '0;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= sel;
      if (start)
        tx_sh <= rsp_byte;
      else if (fall)
        tx_sh <= (bit_cnt == '0) ? rsp_byte : {tx_sh[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso = tx_sh[BYTE_W-1];

  p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (!cmd_valid && !wr_valid));
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && wr_valid));
endmodule

// File: rtl/spi_text_buf.sv
module spi_text_buf #(
  parameter int DEPTH  = 256,
  parameter int MARGIN = 16,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          ready
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int THR = DEPTH - MARGIN;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, count_nxt;
  logic          full, empty, push, pop;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign push  = wr_en & ~full;
  assign pop   = rd_en & ~empty;

  always_comb begin
    count_nxt = count;
    if (push && !pop)      count_nxt = count + 1'b1;
    else if (pop && !push) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
      ready    <= 1'b1;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count    <= count_nxt;
      rd_valid <= pop;
      ready    <= (count_nxt < CW'(THR));
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> (count == CW'(DEPTH)));
  p_ready_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (count < $past(count)));
  p_ready_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> (count > $past(count)));
  p_empty_read_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> !rd_valid);
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int MARGIN      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic [BYTE_W-1:0] rsp_byte,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ready
);
  // bit order: cs_n, ss_n, sclk, mosi
  logic [3:0] pins_s;
  logic       sel;

  spi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, ss_n, sclk, mosi}),
    .q   (pins_s)
  );

  assign sel = ~pins_s[3] & ~pins_s[2];

  spi_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .sclk_s    (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .rsp_byte  (rsp_byte),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data)
  );

  spi_text_buf #(.DEPTH(DEPTH), .MARGIN(MARGIN), .DW(BYTE_W)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_valid),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .ready    (ready)
  );
endmodule

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
  localparam int DEPTH = 256;
  localparam int THR   = 240;
  localparam int HALF  = 8;

  logic clk = 0, rst = 1;
  logic sclk = 0, ss_n = 1, cs_n = 0, mosi = 0, rd_en = 0;
  logic [7:0] rsp_byte = 8'h00;
  logic miso, miso_oe, cmd_valid, wr_valid, rd_valid, ready;
  logic [15:0] cmd_word;
  logic [7:0] wr_data, rd_data;

  always #5 clk = ~clk;

  spi_cmd_slave dut (
    .clk(clk), .rst(rst), .sclk(sclk), .ss_n(ss_n), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .rsp_byte(rsp_byte),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .ready(ready)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] tx_arr [300];
  logic [15:0] got_cmd [$];
  logic [7:0]  got_wr [$];
  logic [7:0]  model [$];
  int miso_err, oe_err;

  always @(negedge clk) begin
    if (!rst && cmd_valid) got_cmd.push_back(cmd_word);
    if (!rst && wr_valid)  got_wr.push_back(wr_data);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ready(input int level);
    return level < THR;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // host-side transfer of nb whole bytes plus extra bits
  task automatic xfer(input int nb, input int extra, input logic [7:0] rsp);
    logic [7:0] rx;
    rsp_byte = rsp;
    miso_err = 0; oe_err = 0;
    got_cmd.delete(); got_wr.delete();
    ss_n = 0;
    wait_clk(HALF);
    if (miso_oe !== !cs_n) oe_err++;
    for (int b = 0; b < nb + (extra > 0 ? 1 : 0); b++) begin
      int nbits;
      nbits = (b < nb) ? 8 : extra;
      rx = 0;
      for (int i = 7; i > 7 - nbits; i--) begin
        wait_clk(HALF / 2);
        mosi = tx_arr[b][i];
        wait_clk(HALF / 2);
        sclk = 1;
        wait_clk(HALF);
        rx[i] = miso;
        sclk = 0;
      end
      if (b < nb && !cs_n && rx !== rsp) miso_err++;
    end
    wait_clk(HALF);
    ss_n = 1;
    wait_clk(4);
    if (miso_oe !== 1'b0) oe_err++;
    wait_clk(HALF);
    if (!cs_n) for (int b = 2; b < nb; b++)
      if (model.size() < DEPTH) model.push_back(tx_arr[b]);
  endtask

  task automatic drain(input string req);
    int data_err = 0, rdy_err = 0;
    while (model.size() > 0) begin
      logic [7:0] e;
      e = model.pop_front();
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      if (rd_valid !== 1'b1 || rd_data !== e) data_err++;
      if (ready !== exp_ready(model.size())) rdy_err++;
    end
    check(data_err == 0, {req, " R4 R10 buffer order"}, data_err, 0);
    check(rdy_err == 0, {req, " R8 ready on drain"}, rdy_err, 0);
  endtask

  task automatic check_frame(input int nb, input string req);
    check(miso_err == 0, {req, " R6 miso bytes"}, miso_err, 0);
    check(oe_err == 0, {req, " R7 miso_oe"}, oe_err, 0);
    if (nb >= 2) begin
      check(got_cmd.size() == 1 && got_cmd[0] === {tx_arr[0], tx_arr[1]},
            {req, " R3 cmd_word"}, got_cmd.size() > 0 ? got_cmd[0] : -1,
            {tx_arr[0], tx_arr[1]});
    end else
      check(got_cmd.size() == 0, {req, " R5 no cmd"}, got_cmd.size(), 0);
    begin
      int we = 0;
      if (got_wr.size() != (nb > 2 ? nb - 2 : 0)) we++;
      else foreach (got_wr[k]) if (got_wr[k] !== tx_arr[k + 2]) we++;
      check(we == 0, {req, " R4 payload strobes"}, got_wr.size(), nb > 2 ? nb - 2 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    wait_clk(5);
    rst = 0;
    wait_clk(2);
    // R1 reset state
    check(ready === 1'b1, "R1 ready", ready, 1);
    check(miso_oe === 1'b0, "R1 miso_oe", miso_oe, 0);
    check(!cmd_valid && !wr_valid && !rd_valid, "R1 strobes", {cmd_valid, wr_valid, rd_valid}, 0);

    // R3 command only
    tx_arr[0] = 8'hA5; tx_arr[1] = 8'h3C;
    xfer(2, 0, 8'hC3);
    check_frame(2, "cmd only");

    // R4 payload
    tx_arr[0] = 8'h12; tx_arr[1] = 8'h80; tx_arr[2] = 8'h01; tx_arr[3] = 8'hFF; tx_arr[4] = 8'h5A;
    xfer(5, 0, 8'h96);
    check_frame(5, "payload");
    drain("payload");

    // R2 cs_n high: ignored
    cs_n = 1;
    tx_arr[0] = 8'h77; tx_arr[1] = 8'h66; tx_arr[2] = 8'h55;
    xfer(3, 0, 8'h00);
    check(got_cmd.size() == 0 && got_wr.size() == 0, "R2 no strobes", got_cmd.size() + got_wr.size(), 0);
    check(oe_err == 0, "R2 miso_oe low", oe_err, 0);
    cs_n = 0;
    check(ready === 1'b1 && rd_valid === 1'b0, "R2 buffer untouched", ready, 1);

    // R5 partial commands
    tx_arr[0] = 8'hDE;
    xfer(1, 0, 8'h11);
    check(got_cmd.size() == 0, "R5 one byte", got_cmd.size(), 0);
    tx_arr[0] = 8'hBE; tx_arr[1] = 8'hEF;
    xfer(1, 4, 8'h22);
    check(got_cmd.size() == 0, "R5 twelve bits", got_cmd.size(), 0);
    tx_arr[0] = 8'h0F; tx_arr[1] = 8'hF0; tx_arr[2] = 8'h42;
    xfer(3, 0, 8'h81);
    check_frame(3, "R5 after partial");
    drain("R5 after partial");

    // random transactions
    for (int t = 0; t < 20; t++) begin
      int nb;
      nb = $urandom_range(0, 12);
      for (int b = 0; b < nb; b++) tx_arr[b] = 8'($urandom);
      xfer(nb, 0, 8'($urandom));
      check_frame(nb, $sformatf("rand%0d", t));
      if (t % 5 == 4) drain("rand");
    end
    drain("rand end");

    // R8 / R9 fill
    tx_arr[0] = 8'h10; tx_arr[1] = 8'h20;
    for (int b = 2; b < 241; b++) tx_arr[b] = 8'(b * 7);
    xfer(241, 0, 8'hE7);
    check(ready === 1'b1, "R8 239 bytes ready high", ready, 1);
    tx_arr[2] = 8'h99;
    xfer(3, 0, 8'h3A);
    check(ready === 1'b0, "R8 240 bytes ready low", ready, 0);
    for (int b = 2; b < 22; b++) tx_arr[b] = 8'(b + 8'h40);
    xfer(22, 0, 8'h5C);
    check(got_wr.size() == 20, "R9 strobes while full", got_wr.size(), 20);
    check(model.size() == DEPTH, "R9 model full", model.size(), DEPTH);
    drain("R9 full");

    // R10 empty read
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
    check(rd_valid === 1'b0, "R10 empty read", rd_valid, 0);
    check(ready === 1'b1, "R8 ready after drain", ready, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule